// File: doc/BRIEF.md
# SDRAM Clock-Enable Suspend Controller

This block watches the clock-enable input of a synchronous DRAM and tells the rest of the device, one cycle ahead, whether the next rising clock edge counts. Each rising edge samples clock-enable. A high sample qualifies the following edge. A low sample disqualifies it, so every internal register gated by the edge-valid strobe holds its value through that edge.

What a low sample means depends on whether a burst is running. If a burst is in progress, the block enters clock suspend: the burst is frozen where it stands and resumes once clock-enable is high again. If no burst is in progress, the block enters power-down, which lasts until clock-enable is sampled high. While either hold state is active, the burst flag is ignored. A burst that is frozen stays frozen, and a device that is asleep stays asleep, until clock-enable returns.

The controller has three modes: `MODE_RUN`, `MODE_SUSPEND` and `MODE_PWRDN`. The named transitions are:
- hold: run to suspend, on a low sample with a burst active.
- sleep: run to power-down, on a low sample with no burst.
- resume: suspend to run, on a high sample.
- wake: power-down to run, on a high sample.
- stay: any mode to itself otherwise.

The array, refresh timing and command decoding are handled elsewhere.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in run mode: after a clock edge with `rst` high, `edge_valid`=1, `suspended`=0 and `powered_down`=0.
- R2: A high `cke` sample at edge n drives `edge_valid` to 1 for the cycle after edge n, so edge n+1 is valid.
- R3: A low `cke` sample at edge n drives `edge_valid` to 0 for the cycle after edge n, so edge n+1 is invalid.
- R4: In run mode, a low `cke` sample with `burst_active`=1 sets `suspended`=1 and keeps `powered_down`=0 from the next cycle on.
- R5: In run mode, a low `cke` sample with `burst_active`=0 sets `powered_down`=1 and keeps `suspended`=0 from the next cycle on.
- R6: In suspend or power-down, a low `cke` sample keeps the same mode whatever the value of `burst_active`.
- R7: In suspend or power-down, a high `cke` sample returns the block to run mode at the next cycle, with both flags 0.
- R8: `suspended` and `powered_down` are never both 1, and `edge_valid` is 1 exactly when neither flag is 1.
- R9: A burst counter that advances only on edges where `edge_valid` and `burst_active` are both 1 advances exactly once for each such edge. It does not move on invalid edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable sample input |
| burst_active | input | 1 | High while a read or write burst is in progress |
| edge_valid | output | 1 | High when the coming rising edge is a valid internal edge |
| suspended | output | 1 | High while a burst is frozen by clock suspend |
| powered_down | output | 1 | High while in power-down |

## Verification
The assertions assume that `cke` and `burst_active` are stable at each rising edge. They also assume that `rst` is a clean synchronous level; they place no constraint on the order in which `cke` and `burst_active` change. The bench drives every input on the falling edge, half a period away from sampling. It walks through each named transition, including toggling `burst_active` during suspend and during power-down. It also applies a reset from power-down. A bench-side burst counter gated by `edge_valid` is compared against the number of qualified edges the stimulus implies.

// File: rtl/cke_susp_pkg.sv
package cke_susp_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_SUSPEND = 2'd1,
        MODE_PWRDN   = 2'd2
    } cke_mode_e;

    // Status bundle as seen at the block edge.
    typedef struct packed {
        logic edge_valid;
        logic suspended;
        logic powered_down;
    } cke_status_t;

endpackage

// File: rtl/cke_transition.sv
// Combinational next-mode selection: hold, sleep, resume, wake, stay.
module cke_transition
    import cke_susp_pkg::*;
(
    input  cke_mode_e cur_mode,
    input  logic      cke_smp,
    input  logic      burst_smp,
    output cke_mode_e nxt_mode
);

    always_comb begin
        nxt_mode = cur_mode;
        unique case (cur_mode)
            MODE_RUN: begin
                if (!cke_smp) begin
                    // hold when a burst is running, sleep otherwise
                    nxt_mode = burst_smp ? MODE_SUSPEND : MODE_PWRDN;
                end
            end
            MODE_SUSPEND: begin
                // resume on a high sample; burst flag is ignored here
                if (cke_smp) nxt_mode = MODE_RUN;
            end
            MODE_PWRDN: begin
                // wake on a high sample; burst flag is ignored here
                if (cke_smp) nxt_mode = MODE_RUN;
            end
            default: nxt_mode = MODE_RUN;
        endcase
    end

endmodule

// File: rtl/cke_mode_reg.sv
// State register: the sampled clock-enable takes effect on the next edge.
module cke_mode_reg
    import cke_susp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    input  logic      burst_active,
    input  cke_mode_e nxt_mode,
    output cke_mode_e cur_mode
);

    always_ff @(posedge clk) begin
        if (rst) cur_mode <= MODE_RUN;
        else     cur_mode <= nxt_mode;
    end

    // R6: low sample keeps a hold mode, whatever the burst flag does
    a_r6_pwrdn_sticky: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_PWRDN && !cke) |=> (cur_mode == MODE_PWRDN));
    a_r6_suspend_sticky: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_SUSPEND && !cke) |=> (cur_mode == MODE_SUSPEND));
    // R4 / R5: which hold mode is entered from run
    a_r4_hold_entry: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_RUN && !cke && burst_active) |=> (cur_mode == MODE_SUSPEND));
    a_r5_sleep_entry: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_RUN && !cke && !burst_active) |=> (cur_mode == MODE_PWRDN));

endmodule

// File: rtl/cke_status_decode.sv
// Output process: one status bundle per mode.
module cke_status_decode
    import cke_susp_pkg::*;
(
    input  cke_mode_e   cur_mode,
    output cke_status_t status
);

    always_comb begin
        status = '{edge_valid: 1'b1, suspended: 1'b0, powered_down: 1'b0};
        unique case (cur_mode)
            MODE_RUN:     status = '{edge_valid: 1'b1, suspended: 1'b0, powered_down: 1'b0};
            MODE_SUSPEND: status = '{edge_valid: 1'b0, suspended: 1'b1, powered_down: 1'b0};
            MODE_PWRDN:   status = '{edge_valid: 1'b0, suspended: 1'b0, powered_down: 1'b1};
            default:      status = '{edge_valid: 1'b1, suspended: 1'b0, powered_down: 1'b0};
        endcase
    end

endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl
    import cke_susp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic burst_active,
    output logic edge_valid,
    output logic suspended,
    output logic powered_down
);

    cke_mode_e   cur_mode;
    cke_mode_e   nxt_mode;
    cke_status_t status;

    cke_transition u_trans (
        .cur_mode  (cur_mode),
        .cke_smp   (cke),
        .burst_smp (burst_active),
        .nxt_mode  (nxt_mode)
    );

    cke_mode_reg u_mode (
        .clk          (clk),
        .rst          (rst),
        .cke          (cke),
        .burst_active (burst_active),
        .nxt_mode     (nxt_mode),
        .cur_mode     (cur_mode)
    );

    cke_status_decode u_dec (
        .cur_mode (cur_mode),
        .status   (status)
    );

    assign edge_valid   = status.edge_valid;
    assign suspended    = status.suspended;
    assign powered_down = status.powered_down;

    // R1: reset edge leaves run mode
    a_r1_reset_run: assert property (@(posedge clk)
        rst |=> (edge_valid && !suspended && !powered_down));
    // R2 / R3: sample qualifies the following edge
    a_r2_high_qualifies: assert property (@(posedge clk) disable iff (rst)
        cke |=> edge_valid);
    a_r3_low_disqualifies: assert property (@(posedge clk) disable iff (rst)
        !cke |=> !edge_valid);
    // R7: high sample leaves either hold mode
    a_r7_exit_hold: assert property (@(posedge clk) disable iff (rst)
        ((suspended || powered_down) && cke) |=> (!suspended && !powered_down));
    // R8: flags exclusive, edge_valid is their complement
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(suspended && powered_down) && (edge_valid == !(suspended || powered_down)));

endmodule

// File: tb/tb_cke_suspend_ctrl.sv
module tb_cke_suspend_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1;
    logic burst_active = 1'b0;
    logic edge_valid, suspended, powered_down;

    always #10 clk = ~clk;  // 50 MHz

    cke_suspend_ctrl dut (
        .clk(clk), .rst(rst), .cke(cke), .burst_active(burst_active),
        .edge_valid(edge_valid), .suspended(suspended), .powered_down(powered_down)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    int model_mode = 0;   // 0 run, 1 suspend, 2 power-down
    int exp_cnt = 0;
    int burst_cnt = 0;
    bit done = 0;

    // Burst counter gated by the qualifier (R9)
    always @(posedge clk)
        if (!rst && edge_valid && burst_active) burst_cnt <= burst_cnt + 1;

    task automatic step(input logic r, input logic c, input logic b, input string tag);
        @(negedge clk);
        rst = r; cke = c; burst_active = b;
        if (!r && model_mode == 0 && b) exp_cnt++;
        if (r || c) model_mode = 0;
        else if (model_mode == 0) model_mode = b ? 1 : 2;
        exp_q.push_back({model_mode == 0, model_mode == 1, model_mode == 2});
        tag_q.push_back(tag);
    endtask

    task automatic check_cnt(input string tag);
        @(posedge clk); #3;
        n_cmp++;
        if (burst_cnt != exp_cnt) begin
            n_bad++;
            $display("FAIL %s burst count actual=%0d expected=%0d", tag, burst_cnt, exp_cnt);
        end
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({edge_valid, suspended, powered_down} !== e) begin
                    n_bad++;
                    $display("FAIL %s {valid,susp,pd} actual=%b expected=%b", t,
                             {edge_valid, suspended, powered_down}, e);
                end
            end
        end
    end

    initial begin
        step(1, 1, 0, "R1 reset");
        step(1, 0, 1, "R1 reset");
        step(0, 1, 0, "R2 idle high");
        step(0, 1, 1, "R2 burst high");
        step(0, 1, 1, "R2 burst high");
        step(0, 0, 1, "R4 hold entry");
        step(0, 0, 1, "R6 suspend stays");
        step(0, 0, 0, "R6 suspend ignores burst drop");
        step(0, 0, 1, "R3 low keeps invalid");
        step(0, 1, 1, "R7 resume");
        step(0, 1, 1, "R2 burst continues");
        step(0, 0, 1, "R4 second hold");
        step(0, 1, 1, "R7 resume again");
        check_cnt("R9 after suspend");
        step(0, 1, 0, "R2 burst done");
        step(0, 0, 0, "R5 sleep entry");
        step(0, 0, 1, "R6 power-down ignores burst");
        step(0, 0, 0, "R6 power-down stays");
        step(0, 1, 0, "R7 wake");
        step(0, 0, 0, "R5 sleep again");
        step(1, 0, 0, "R1 reset from power-down");
        step(0, 1, 1, "R2 after reset");
        step(0, 0, 1, "R4 hold after reset");
        step(0, 1, 0, "R7 resume, burst ended");
        step(0, 0, 0, "R5 sleep after resume");
        step(0, 1, 0, "R8 wake exclusive");
        step(0, 1, 1, "R2 burst");
        check_cnt("R9 final");
        repeat (3) @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule